// File: doc/BRIEF.md
# Microsecond Interval Timer Bank

A bank of four independent down-counting interval timers that advance on a one-cycle microsecond tick supplied from outside the block. Each timer is programmed with one control word that carries an enable flag, a periodic-mode flag and a 29-bit count. The count that software writes is the number of ticks to expiry minus one. When a timer expires it latches an active-high level interrupt. In one-shot mode the timer then disarms itself. In periodic mode it reloads the programmed count and keeps running.

Software reaches each timer through two words on a simple synchronous register bus. The control word sits at offset +0x0 of a timer's window. The status/clear word sits at offset +0x4. The four windows start at 0x00, 0x08, 0x50 and 0x58 for timers 0 to 3. A write to the status/clear word with bit 30 set drops the interrupt. A read of that word returns the remaining count and the pending flag. Reads are combinational from the address. Writes take effect at the next clock edge when `wr_en` is high. The bus has no back-pressure and no handshake.

Top module: `usec_timer_bank`

## Requirements
- R1: After reset every `irq` bit is 0, and every control and status word reads 0.
- R2: Writing a control word with bit 31 = 1, bit 30 = 0 and count N-1 (bits 28:0) raises that timer's `irq` on exactly the Nth tick after the write. On that tick bit 31 of its control word reads back 0 and the count stops at 0.
- R3: A count of 0 with bit 31 = 1 expires on the first tick after the write.
- R4: With bits 31 and 30 both set, the timer reloads its programmed count on each expiry and raises `irq` every N ticks, without software action.
- R5: `irq` is a level that stays high across further ticks. It clears only when the status/clear word is written with bit 30 = 1. A write there with bit 30 = 0 leaves it set.
- R6: Writing 0 to a control word stops that timer: later ticks raise no interrupt and the count reads 0.
- R7: A control-word write to a running timer loads the new count at once. Expiry is then counted from the new value.
- R8: The windows are at 0x00, 0x08, 0x50 and 0x58, each with the control word at +0x0 and the status/clear word at +0x4. An access to one timer leaves the others unchanged. Other addresses read 0, and writes to them have no effect.
- R9: Ticks do nothing to a timer whose enable bit is 0, and the counter holds its value.
- R10: If an expiry and a clear write land in the same cycle, the interrupt stays set.
- R11: The status/clear word reads back the remaining count in bits 28:0 and the pending flag in bit 30. The control word reads back bits 31, 30 and 28:0 as written, and bit 29 reads 0. The largest count is 0x1FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle microsecond tick |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe for `addr` and `wdata` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 4 | Level interrupt, one bit per timer |

## Verification
Several count patterns are used. A one-shot count of 4 and a count of 0 separate correct minus-one handling from an off-by-one. A periodic count of 2 shows that the reload restores the programmed value rather than zero or the maximum. An all-ones word shows how the reserved bit 29 and the 29-bit count saturate on readback. The patterns also cover a mid-flight rewrite, a write with enable clear, and a clear that coincides with an expiry. Together they separate immediate reload from deferred reload, tick gating from free running, and set-over-clear priority from clear-over-set. Each timer is driven from its own window while the other `irq` bits are watched, so an address-map error shows up as a stray interrupt.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

  localparam int unsigned UT_NUM    = 4;
  localparam int unsigned UT_CNT_W  = 29;
  localparam int unsigned UT_DATA_W = 32;
  localparam int unsigned UT_ADDR_W = 8;

  // control word bit positions (software-visible)
  localparam int unsigned UT_EN_BIT   = 31;
  localparam int unsigned UT_PER_BIT  = 30;
  // status/clear word: clear strobe on write, pending flag on read
  localparam int unsigned UT_CLR_BIT  = 30;

  localparam int unsigned UT_CTRL_OFS = 0;
  localparam int unsigned UT_STAT_OFS = 4;

  typedef enum logic [1:0] {
    UT_IDLE    = 2'b00,
    UT_ONESHOT = 2'b10,
    UT_PERIOD  = 2'b11
  } utmr_mode_e;

  // base byte address of timer window idx: 0x00, 0x08, 0x50, 0x58
  function automatic int unsigned utmr_base(int unsigned idx);
    return (((idx >> 1) & 1) * 32'h50) + ((idx & 1) * 32'h08);
  endfunction

endpackage

// File: rtl/utmr_decode.sv
module utmr_decode
  import utmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = UT_NUM,
  parameter int unsigned ADDR_W  = UT_ADDR_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  output logic [NUM_TMR-1:0] sel_ctrl,
  output logic [NUM_TMR-1:0] sel_stat,
  output logic [NUM_TMR-1:0] wr_ctrl,
  output logic [NUM_TMR-1:0] wr_stat
);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_win
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(utmr_base(g) + UT_CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(utmr_base(g) + UT_STAT_OFS);
    assign sel_ctrl[g] = (addr == CTRL_A);
    assign sel_stat[g] = (addr == STAT_A);
    assign wr_ctrl[g]  = wr_en & sel_ctrl[g];
    assign wr_stat[g]  = wr_en & sel_stat[g];
  end

endmodule

// File: rtl/utmr_channel.sv
module utmr_channel
  import utmr_pkg::*;
#(
  parameter int unsigned CNT_W  = UT_CNT_W,
  parameter int unsigned DATA_W = UT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] stat_word,
  output logic              irq
);

  localparam int unsigned PAD_W = DATA_W - CNT_W - 2;

  utmr_mode_e       mode_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             pend_q;

  logic running;
  logic at_zero;
  logic expire;
  logic clr_req;

  assign running = mode_q[1];
  assign at_zero = (count_q == '0);
  assign expire  = running & tick & at_zero & ~wr_ctrl;
  assign clr_req = wr_stat & wdata[UT_CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= UT_IDLE;
      reload_q <= '0;
      count_q  <= '0;
    end else if (wr_ctrl) begin
      if (!wdata[UT_EN_BIT])       mode_q <= UT_IDLE;
      else if (wdata[UT_PER_BIT])  mode_q <= UT_PERIOD;
      else                         mode_q <= UT_ONESHOT;
      reload_q <= wdata[CNT_W-1:0];
      count_q  <= wdata[CNT_W-1:0];
    end else if (running && tick) begin
      if (at_zero) begin
        if (mode_q == UT_PERIOD) count_q <= reload_q;
        else                     mode_q  <= UT_IDLE;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (expire)  pend_q <= 1'b1;
    else if (clr_req) pend_q <= 1'b0;
  end

  // idle keeps the periodic flag readable only while armed
  logic per_rd;
  assign per_rd = (mode_q == UT_PERIOD);

  assign ctrl_word = {running, per_rd, {PAD_W{1'b0}}, reload_q};
  assign stat_word = {1'b0, pend_q, {PAD_W{1'b0}}, count_q};
  assign irq       = pend_q;

endmodule

// File: rtl/utmr_rdmux.sv
module utmr_rdmux
  import utmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = UT_NUM,
  parameter int unsigned DATA_W  = UT_DATA_W
) (
  input  logic [NUM_TMR-1:0] sel_ctrl,
  input  logic [NUM_TMR-1:0] sel_stat,
  input  logic [DATA_W-1:0]  ctrl_words [NUM_TMR],
  input  logic [DATA_W-1:0]  stat_words [NUM_TMR],
  output logic [DATA_W-1:0]  rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (sel_ctrl[i]) rdata = rdata | ctrl_words[i];
      if (sel_stat[i]) rdata = rdata | stat_words[i];
    end
  end

endmodule

// File: rtl/usec_timer_bank.sv
module usec_timer_bank
  import utmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = UT_NUM,
  parameter int unsigned CNT_W   = UT_CNT_W,
  parameter int unsigned DATA_W  = UT_DATA_W,
  parameter int unsigned ADDR_W  = UT_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_TMR-1:0] irq
);

  logic [NUM_TMR-1:0] sel_ctrl, sel_stat, wr_ctrl, wr_stat;
  logic [DATA_W-1:0]  ctrl_words [NUM_TMR];
  logic [DATA_W-1:0]  stat_words [NUM_TMR];

  utmr_decode #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .sel_ctrl (sel_ctrl),
    .sel_stat (sel_stat),
    .wr_ctrl  (wr_ctrl),
    .wr_stat  (wr_stat)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    utmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_ctrl   (wr_ctrl[g]),
      .wr_stat   (wr_stat[g]),
      .wdata     (wdata),
      .ctrl_word (ctrl_words[g]),
      .stat_word (stat_words[g]),
      .irq       (irq[g])
    );
  end

  utmr_rdmux #(.NUM_TMR(NUM_TMR), .DATA_W(DATA_W)) u_rd (
    .sel_ctrl   (sel_ctrl),
    .sel_stat   (sel_stat),
    .ctrl_words (ctrl_words),
    .stat_words (stat_words),
    .rdata      (rdata)
  );

endmodule

// File: rtl/utmr_checker.sv
module utmr_checker
  import utmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = UT_NUM,
  parameter int unsigned DATA_W  = UT_DATA_W,
  parameter int unsigned ADDR_W  = UT_ADDR_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_TMR-1:0] irq
);

  logic [NUM_TMR-1:0] hit_c, hit_s;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    assign hit_c[g] = (addr == ADDR_W'(utmr_base(g) + UT_CTRL_OFS));
    assign hit_s[g] = (addr == ADDR_W'(utmr_base(g) + UT_STAT_OFS));

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] && !(wr_en && hit_s[g] && wdata[UT_CLR_BIT]) |=> irq[g]); // R5

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && hit_s[g] && wdata[UT_CLR_BIT] && !tick |=> !irq[g]); // R5

    AST_NO_TICK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !irq[g] && !tick |=> !irq[g]); // R9

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !irq[g] && wr_en && hit_c[g] && !wdata[UT_EN_BIT] |=> !irq[g]); // R6
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c == '0) && (hit_s == '0) |-> rdata == '0); // R8

endmodule

bind usec_timer_bank utmr_checker #(
  .NUM_TMR (NUM_TMR),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_utmr_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .addr  (addr),
  .wr_en (wr_en),
  .wdata (wdata),
  .rdata (rdata),
  .irq   (irq)
);

// File: tb/tb_usec_timer_bank.sv
`timescale 1ns/1ps
module tb_usec_timer_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usec_timer_bank dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one bus cycle: optional write and optional tick in the same edge
  task automatic cyc(logic we, logic [7:0] a, logic [31:0] d, logic tk);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0, 1'b1);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {28'h0, irq}, 32'h0);
    rd(8'h00, v); chk("R1 ctrl0", v, 32'h0);
    rd(8'h5C, v); chk("R1 stat3", v, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(8'h00, 32'h8000_0004);
    ticks(4);
    chk("R2 no irq before Nth tick", {28'h0, irq}, 32'h0);
    rd(8'h04, v); chk("R2 count at zero", v, 32'h0);
    ticks(1);
    chk("R2 irq on Nth tick", {28'h0, irq}, 32'h1);
    rd(8'h00, v); chk("R2 enable self-clears", v, 32'h0000_0004);
    rd(8'h04, v); chk("R11 status pending", v, 32'h4000_0000);
    ticks(3);
    chk("R5 level holds", {28'h0, irq}, 32'h1);
    wr(8'h04, 32'hBFFF_FFFF);
    chk("R5 clear bit0 ignored", {28'h0, irq}, 32'h1);
    wr(8'h04, 32'h4000_0000);
    chk("R5 write-one clears", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_zero();
    wr(8'h08, 32'h8000_0000);
    ticks(1);
    chk("R3 zero expires first tick", {28'h0, irq}, 32'h2);
    wr(8'h0C, 32'h4000_0000);
    chk("R8 clear timer1 only", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(8'h50, 32'hC000_0002);
    ticks(3);
    chk("R4 first period", {28'h0, irq}, 32'h4);
    rd(8'h54, v); chk("R4 reloaded count", v, 32'h4000_0002);
    wr(8'h54, 32'h4000_0000);
    ticks(2);
    chk("R4 mid period quiet", {28'h0, irq}, 32'h0);
    ticks(1);
    chk("R4 second period", {28'h0, irq}, 32'h4);
    rd(8'h50, v); chk("R4 still armed", v, 32'hC000_0002);
    wr(8'h50, 32'h0);
    wr(8'h54, 32'h4000_0000);
    ticks(10);
    chk("R6 stopped no irq", {28'h0, irq}, 32'h0);
    rd(8'h54, v); chk("R6 count zero", v, 32'h0);
  endtask

  task automatic t_rewrite();
    logic [31:0] v;
    wr(8'h58, 32'h8000_0009);
    ticks(3);
    rd(8'h5C, v); chk("R7 counting down", v, 32'h6);
    wr(8'h58, 32'h8000_0001);
    rd(8'h5C, v); chk("R7 immediate reload", v, 32'h1);
    ticks(1);
    chk("R7 not yet", {28'h0, irq}, 32'h0);
    ticks(1);
    chk("R7 expiry from new value", {28'h0, irq}, 32'h8);
    wr(8'h5C, 32'h4000_0000);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0005);
    ticks(4);
    rd(8'h04, v); chk("R9 count holds when disabled", v, 32'h5);
    chk("R9 no irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_collide();
    wr(8'h08, 32'h8000_0000);
    cyc(1'b1, 8'h0C, 32'h4000_0000, 1'b1);
    chk("R10 set beats clear", {28'h0, irq}, 32'h2);
    wr(8'h0C, 32'h4000_0000);
  endtask

  task automatic t_max_and_map();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R11 ctrl readback", v, 32'hDFFF_FFFF);
    rd(8'h04, v); chk("R11 max count", v, 32'h1FFF_FFFF);
    ticks(1);
    rd(8'h04, v); chk("R11 max decrements", v, 32'h1FFF_FFFE);
    wr(8'h00, 32'h0);
    rd(8'h20, v); chk("R8 unmapped read", v, 32'h0);
    wr(8'h20, 32'h8000_0000);
    wr(8'h10, 32'h8000_0000);
    ticks(2);
    chk("R8 unmapped write no effect", {28'h0, irq}, 32'h0);
    rd(8'h50, v); chk("R8 timer2 untouched", v, 32'h0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oneshot();
    t_zero();
    t_periodic();
    t_rewrite();
    t_disabled();
    t_collide();
    t_max_and_map();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule